// File: doc/BRIEF.md
# Current-Mode PWM Window Generator

This block produces the gate-drive PWM for a brushless motor controller around a periodic measurement window. The window is a short interval in every PWM period during which the power stage is off. Back-EMF zero-crossing and end-of-demagnetization sampling may only take place inside it. The window period and width are programmable counts of clock cycles.

In current mode the PWM turns on when a window closes. It turns off when the next window opens, or earlier when the current comparator trips. After a trip the output stays off until the next window closes. In voltage mode the PWM from an external timer is passed through, and the current comparator only acts as a limit that holds the output low. Both raw comparator inputs go through two-flop synchronizers.

The block also samples the phase comparator at the end of each window. It does this only while zero-crossing detection is armed. The end-of-demagnetization event for a step arms detection, and the start of a new step disarms it.

Top module: `pwm_window_gen`

## Requirements
- R1: In current mode (`cur_mode`=1), `pwm_out` rises only in the first cycle after `meas_win` falls. It does so at every window close unless the synchronized trip is high.
- R2: In current mode, `pwm_out` falls in the cycle in which `meas_win` rises, and it stays low while the window is open.
- R3: The window count runs 0..`win_period` and wraps to 0 once it reaches or exceeds `win_period`, so one period lasts `win_period`+1 cycles. `meas_win` is high while the count is below `win_width`. A width of 0 keeps the window closed. A width above `win_period` keeps it open. After reset the count starts at 0 with the window closed.
- R4: A high level on `cur_trip_in` forces `pwm_out` low from the third rising clock edge onward (two synchronizer flops, then the output flop). This holds in both modes.
- R5: In current mode, once the synchronized trip has driven `pwm_out` low, it stays low until the next window close, even if the trip releases earlier.
- R6: In voltage mode (`cur_mode`=0), `pwm_out` equals `timer_pwm` from the previous cycle, ANDed with the inverted synchronized trip.
- R7: If detection is armed during the last cycle of an open window, `phase_latch` takes the synchronized `phase_cmp_in` (two flops), and `zc_valid` is high for the single cycle after the window closes. Otherwise `phase_latch` holds and `zc_valid` stays low.
- R8: `demag_end` sets `zc_armed` on the next edge and `step_new` clears it. When both are high in the same cycle, `step_new` wins.
- R9: While reset is asserted, `pwm_out`, `meas_win`, `zc_armed`, `phase_latch` and `zc_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_mode | input | 1 | 1 = current mode, 0 = voltage mode |
| win_period | input | 8 | Window period minus one, in clock cycles |
| win_width | input | 8 | Window width in clock cycles; 0 disables the window |
| timer_pwm | input | 1 | External timer PWM used in voltage mode |
| cur_trip_in | input | 1 | Raw current comparator output, high = over limit |
| phase_cmp_in | input | 1 | Raw phase (back-EMF) comparator output |
| demag_end | input | 1 | End-of-demagnetization pulse; arms sampling |
| step_new | input | 1 | New commutation step pulse; disarms sampling |
| pwm_out | output | 1 | Registered PWM to the channel stage |
| meas_win | output | 1 | Measurement window, high while open |
| zc_armed | output | 1 | Zero-crossing sampling armed |
| phase_latch | output | 1 | Last sampled phase comparator value |
| zc_valid | output | 1 | One-cycle pulse when `phase_latch` was updated |

## Verification
Every cycle, the assertions check the edge relations between the window and the PWM in current mode. They also check that a synchronized trip forces the output off, that voltage-mode pass-through follows the timer PWM, that a zero width holds the window closed, and that the sample pulse lines up with the window close and needs prior arming. Other behaviours only show up as whole sequences driven by the bench's scenarios. These are the exact period and width arithmetic including wrap and over-wide windows, the three-edge trip latency at the pins, the trip staying latched until the next window close after the comparator releases, and the value that lands in the phase latch.

// File: rtl/pwmw_pkg.sv
package pwmw_pkg;

  typedef enum logic {
    MODE_VOLT = 1'b0,
    MODE_CUR  = 1'b1
  } pwm_mode_e;

  // Next PWM level from the mode, the window edges ahead and the trip.
  function automatic logic pwm_next(
    input pwm_mode_e mode,
    input logic      win_open_nxt,
    input logic      win_close_nxt,
    input logic      trip,
    input logic      tmr_pwm,
    input logic      pwm_q
  );
    logic r;
    if (mode == MODE_CUR) begin
      if (win_open_nxt)       r = 1'b0;
      else if (win_close_nxt) r = ~trip;
      else if (trip)          r = 1'b0;
      else                    r = pwm_q;
    end else begin
      r = tmr_pwm & ~trip;
    end
    return r;
  endfunction

endpackage

// File: rtl/pwmw_sync.sv
module pwmw_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pwmw_win_timer.sv
module pwmw_win_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  output logic             win_q,
  output logic             win_open_nxt,
  output logic             win_close_nxt
);

  function automatic logic [CNT_W-1:0] wrap_count(
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim
  );
    return (cnt >= lim) ? '0 : cnt + 1'b1;
  endfunction

  function automatic logic inside_win(
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] wid
  );
    return cnt < wid;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             win_d;

  assign cnt_d         = wrap_count(cnt_q, period);
  assign win_d         = inside_win(cnt_d, width);
  assign win_open_nxt  = win_d & ~win_q;
  assign win_close_nxt = ~win_d & win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/pwmw_drive.sv
module pwmw_drive
  import pwmw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pwm_mode_e mode,
  input  logic      win_open_nxt,
  input  logic      win_close_nxt,
  input  logic      trip_s,
  input  logic      timer_pwm,
  output logic      pwm_q
);

  logic pwm_d;

  assign pwm_d = pwm_next(mode, win_open_nxt, win_close_nxt, trip_s, timer_pwm, pwm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

endmodule

// File: rtl/pwmw_zc_sampler.sv
module pwmw_zc_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_s,
  input  logic win_last,
  input  logic demag_end,
  input  logic step_new,
  output logic armed_q,
  output logic latch_q,
  output logic valid_q
);

  logic take;

  assign take = win_last & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      latch_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (step_new)       armed_q <= 1'b0;
      else if (demag_end) armed_q <= 1'b1;
      valid_q <= take;
      if (take) latch_q <= phase_s;
    end
  end

endmodule

// File: rtl/pwm_window_gen.sv
module pwm_window_gen
  import pwmw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_mode,
  input  logic [CNT_W-1:0] win_period,
  input  logic [CNT_W-1:0] win_width,
  input  logic             timer_pwm,
  input  logic             cur_trip_in,
  input  logic             phase_cmp_in,
  input  logic             demag_end,
  input  logic             step_new,
  output logic             pwm_out,
  output logic             meas_win,
  output logic             zc_armed,
  output logic             phase_latch,
  output logic             zc_valid
);

  localparam int SYNC_N = 2;
  localparam int TRIP_B = 0;
  localparam int PHS_B  = 1;

  logic [SYNC_N-1:0] raw_v;
  logic [SYNC_N-1:0] syn_v;
  logic              trip_s;
  logic              phase_s;
  logic              win_open_nxt;
  logic              win_close_nxt;
  pwm_mode_e         mode;

  assign raw_v[TRIP_B] = cur_trip_in;
  assign raw_v[PHS_B]  = phase_cmp_in;
  assign trip_s        = syn_v[TRIP_B];
  assign phase_s       = syn_v[PHS_B];
  assign mode          = pwm_mode_e'(cur_mode);

  pwmw_sync #(.N(SYNC_N), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_v),
    .d_out (syn_v)
  );

  pwmw_win_timer #(.CNT_W(CNT_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .period        (win_period),
    .width         (win_width),
    .win_q         (meas_win),
    .win_open_nxt  (win_open_nxt),
    .win_close_nxt (win_close_nxt)
  );

  pwmw_drive u_drive (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .win_open_nxt  (win_open_nxt),
    .win_close_nxt (win_close_nxt),
    .trip_s        (trip_s),
    .timer_pwm     (timer_pwm),
    .pwm_q         (pwm_out)
  );

  pwmw_zc_sampler u_zc (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_s   (phase_s),
    .win_last  (win_close_nxt),
    .demag_end (demag_end),
    .step_new  (step_new),
    .armed_q   (zc_armed),
    .latch_q   (phase_latch),
    .valid_q   (zc_valid)
  );

endmodule

// File: rtl/pwmw_checker.sv
module pwmw_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cur_mode,
  input logic [CNT_W-1:0] win_width,
  input logic             timer_pwm,
  input logic             step_new,
  input logic             trip_s,
  input logic             pwm_out,
  input logic             meas_win,
  input logic             zc_armed,
  input logic             zc_valid
);

  assert_on_at_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_out) && $past(cur_mode)) |-> $fell(meas_win));

  assert_off_at_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(meas_win) && $past(cur_mode)) |-> !pwm_out);

  assert_zero_width_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_width == '0) |=> !meas_win);

  assert_trip_forces_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_s |=> !pwm_out);

  assert_voltage_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_mode && !trip_s) |=> (pwm_out == $past(timer_pwm)));

  assert_valid_after_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zc_valid |-> $fell(meas_win));

  assert_valid_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zc_valid |-> $past(zc_armed));

  assert_step_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_new |=> !zc_armed);

endmodule

bind pwm_window_gen pwmw_checker #(.CNT_W(CNT_W)) u_pwmw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cur_mode  (cur_mode),
  .win_width (win_width),
  .timer_pwm (timer_pwm),
  .step_new  (step_new),
  .trip_s    (trip_s),
  .pwm_out   (pwm_out),
  .meas_win  (meas_win),
  .zc_armed  (zc_armed),
  .zc_valid  (zc_valid)
);

// File: tb/pwm_window_gen_bench.sv
module pwm_window_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cur_mode = 1'b1;
  logic [7:0] win_period = 8'd9;
  logic [7:0] win_width = 8'd3;
  logic       timer_pwm = 1'b0;
  logic       cur_trip_in = 1'b0;
  logic       phase_cmp_in = 1'b0;
  logic       demag_end = 1'b0;
  logic       step_new = 1'b0;
  logic       pwm_out, meas_win, zc_armed, phase_latch, zc_valid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pwm_window_gen u_pwm_window_gen (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .win_period(win_period),
    .win_width(win_width), .timer_pwm(timer_pwm), .cur_trip_in(cur_trip_in),
    .phase_cmp_in(phase_cmp_in), .demag_end(demag_end), .step_new(step_new),
    .pwm_out(pwm_out), .meas_win(meas_win), .zc_armed(zc_armed),
    .phase_latch(phase_latch), .zc_valid(zc_valid)
  );

  // Reference model, written from the requirements.
  int unsigned pos;
  bit ref_win, ref_pwm, ref_arm, ref_lat, ref_val;
  bit t1, t2, p1, p2;

  function automatic int unsigned step_pos(int unsigned p, int unsigned per);
    if (p >= per) return 0;
    return p + 1;
  endfunction

  function automatic bit exp_pwm(bit mode, bit w_now, bit w_nxt, bit trip, bit tp, bit cur);
    if (!mode) return tp && !trip;               // R6
    if (w_nxt && !w_now) return 1'b0;            // R2
    if (!w_nxt && w_now) return !trip;           // R1
    return trip ? 1'b0 : cur;                    // R4 R5
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; ref_win = 0; ref_pwm = 0; ref_arm = 0; ref_lat = 0; ref_val = 0;
      t1 = 0; t2 = 0; p1 = 0; p2 = 0;
    end else begin
      int unsigned np;
      bit nw;
      np = step_pos(pos, win_period);
      nw = (np < win_width);
      ref_pwm = exp_pwm(cur_mode, ref_win, nw, t2, timer_pwm, ref_pwm);
      ref_val = ref_win && !nw && ref_arm;
      if (ref_val) ref_lat = p2;
      if (step_new) ref_arm = 0;
      else if (demag_end) ref_arm = 1;
      t2 = t1; t1 = cur_trip_in;
      p2 = p1; p1 = phase_cmp_in;
      pos = np; ref_win = nw;
    end
  end

  task automatic check(bit act, bit exp, string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check(pwm_out, ref_pwm, cur_mode ? "R1 R2 R4 R5 pwm_out" : "R6 R4 pwm_out");
    check(meas_win, ref_win, "R3 meas_win");
    check(phase_latch, ref_lat, "R7 phase_latch");
    check(zc_valid, ref_val, "R7 zc_valid");
    check(zc_armed, ref_arm, "R8 zc_armed");
  endtask

  task automatic cycle_random(int trip_odds);
    @(negedge clk);
    compare_all();
    if ($urandom_range(trip_odds - 1) == 0) cur_trip_in = ~cur_trip_in;
    if ($urandom_range(3) == 0) phase_cmp_in = ~phase_cmp_in;
    if ($urandom_range(5) == 0) timer_pwm = ~timer_pwm;
    demag_end = ($urandom_range(15) == 0);
    step_new  = ($urandom_range(23) == 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: outputs during reset
    repeat (3) begin
      @(negedge clk);
      check(pwm_out, 1'b0, "R9 pwm_out");
      check(meas_win, 1'b0, "R9 meas_win");
      check(zc_armed, 1'b0, "R9 zc_armed");
      check(phase_latch, 1'b0, "R9 phase_latch");
      check(zc_valid, 1'b0, "R9 zc_valid");
    end
    rst_n = 1'b1;

    // R3: zero width keeps window closed, current-mode PWM never starts
    win_width = 8'd0;
    repeat (40) cycle_random(1000);
    // R3: width beyond period keeps window open
    win_width = 8'd12;
    repeat (40) cycle_random(1000);

    // R4 R5: trip latency and latch-off in current mode
    cur_trip_in = 1'b0; win_period = 8'd19; win_width = 8'd4; demag_end = 1'b1;
    repeat (30) @(negedge clk) compare_all();
    demag_end = 1'b0;
    wait (ref_pwm == 1'b1);
    @(negedge clk);
    compare_all();
    cur_trip_in = 1'b1;
    repeat (2) @(negedge clk) compare_all();
    @(negedge clk);
    check(pwm_out, 1'b0, "R4 trip latency");
    cur_trip_in = 1'b0;
    repeat (3) @(negedge clk) begin
      compare_all();
      if (!meas_win) check(pwm_out, 1'b0, "R5 latched off");
    end
    repeat (40) @(negedge clk) compare_all();

    // R8: simultaneous arm and disarm
    @(negedge clk); compare_all();
    demag_end = 1'b1; step_new = 1'b1;
    @(negedge clk); compare_all();
    check(zc_armed, 1'b0, "R8 step_new priority");
    demag_end = 1'b0; step_new = 1'b0;

    // Random segments in both modes
    for (int seg = 0; seg < 60; seg++) begin
      cur_mode   = $urandom_range(1);
      win_period = 8'($urandom_range(40, 3));
      win_width  = ($urandom_range(9) == 0) ? 8'd0 : 8'($urandom_range(int'(win_period) + 2, 1));
      for (int c = 0; c < 250; c++) begin
        cycle_random((seg % 3 == 0) ? 6 : 40);
        if ($urandom_range(299) == 0) cur_mode = ~cur_mode;
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule